// File: doc/BRIEF.md
# Byte-Lane Asynchronous SRAM Sequencer

This block sits between a clocked host and an external static RAM built from several byte-wide dies. The dies share one address bus and one active-low output enable. Each die has its own active-low select and its own active-low write strobe. The host presents a word address, a write-data word, a per-byte lane mask and a read/write flag, and holds its request until the block shows ready. The block then drives the memory pins through a fixed sequence whose lengths are whole clock cycles. Each length is rounded up from the memory's nanosecond minimums and the clock period, so every minimum holds at any clock rate the parameters describe.

Only the dies whose mask bit is set are selected, so a single access moves one to four bytes. Dies that are not selected stay deselected, which is their standby state. During a write the output enable stays high, so the memory never drives the data bus while the block does. The block drives the data bus only while the write strobe is low and for one hold cycle after it. Reads keep the strobes high and pull the output enable low. The block captures the returned bytes in the last cycle before the output enable rises and signals them with a one-cycle valid pulse. Between accesses every die is deselected.

Top module: `sram_lane_ctrl`

## Requirements
- R1: While no access is in progress, ready is high, every lane select and write strobe is high, output enable is high and the data-bus drive enable is low.
- R2: A write lowers select and write strobe together on exactly the lanes whose mask bit is set (mask bit i maps to data bits 8i+7..8i), for WP_CYC cycles (ceil(20 ns / period)); unmasked lanes keep both high.
- R3: Output enable stays high for the whole write. The data bus is driven with the latched write word only during the write pulse and the one cycle after it, and never while output enable is low.
- R4: A read lowers output enable and the selects of the masked lanes for RD_CYC cycles (ceil(25 ns / period)), with all write strobes high.
- R5: Read data is sampled on the last cycle of the read. The result appears with a one-cycle valid pulse in the cycle after output enable rises, and bytes of unmasked lanes read as zero.
- R6: After each access all lanes stay deselected for REC_CYC cycles (at least one) before ready returns. Two write pulses are therefore separated by at least REC_CYC+1 cycles with the strobes high.
- R7: A request is taken only while ready is high. Ready falls in the cycle after acceptance and stays low until the access and its recovery are complete, so a request held high during that time starts nothing new.
- R8: The memory address latched at acceptance stays unchanged until the next acceptance, whatever the host does with its address input meanwhile.
- R9: A read occupies RD_CYC+REC_CYC busy cycles and a write occupies WP_CYC+REC_CYC busy cycles, each count rounded up from the period parameter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Access request, held until ready |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | LANES*LANE_W | Write data |
| be_i | input | LANES | Lane mask, bit i selects byte lane i |
| ready_o | output | 1 | Block idle, request will be taken |
| rvalid_o | output | 1 | One-cycle read-data valid |
| rdata_o | output | LANES*LANE_W | Read data, unmasked lanes zero |
| mem_addr_o | output | ADDR_W | Memory address bus |
| mem_ce_n_o | output | LANES | Per-lane active-low select |
| mem_we_n_o | output | LANES | Per-lane active-low write strobe |
| mem_oe_n_o | output | 1 | Shared active-low output enable |
| mem_dq_o | output | LANES*LANE_W | Data toward memory |
| mem_dq_oe_o | output | 1 | Drive enable for the data pads |
| mem_dq_i | input | LANES*LANE_W | Data from memory pads |

## Verification
The bench builds the block with its default parameters: four 8-bit lanes, a 19-bit address and a 10 ns period. These give a 3-cycle read, a 2-cycle write pulse and a 1-cycle recovery. The rounding is therefore exercised where it matters: 25 ns and 5 ns both round up, and 20 ns is exact. A 1-cycle recovery is the tightest case for the strobe-high gap between back-to-back writes and for the hold cycle in which write data stays driven. The behavioural memory fills each lane with a distinct byte pattern, and undriven lanes return a filler byte, so a lane that is wrongly selected or not zeroed shows up in the read data.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_READ  = 2'd1,
      ST_WRITE = 2'd2,
      ST_RECOV = 2'd3
   } seq_state_e;

   // whole cycles covering t_ps at the given period, never below one
   function automatic int ceil_cycles(input int t_ps, input int per_ps);
      int c;
      c = (t_ps + per_ps - 1) / per_ps;
      if (c < 1) c = 1;
      return c;
   endfunction

   function automatic int max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/sram_lane_timer.sv
module sram_lane_timer #(
   parameter int CW = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_i,
   input  logic [CW-1:0] load_val_i,
   output logic          zero_o
);
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (load_i)         cnt_q <= load_val_i;
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end

   assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/sram_lane_seq.sv
module sram_lane_seq
   import sram_lane_pkg::*;
#(
   parameter int ADDR_W  = 19,
   parameter int LANES   = 4,
   parameter int LANE_W  = 8,
   parameter int RD_CYC  = 3,
   parameter int WP_CYC  = 2,
   parameter int REC_CYC = 1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    req_i,
   input  logic                    we_i,
   input  logic [ADDR_W-1:0]       addr_i,
   input  logic [LANES*LANE_W-1:0] wdata_i,
   input  logic [LANES-1:0]        be_i,
   output logic                    ready_o,
   output logic                    cap_o,
   output logic [LANES-1:0]        sel_o,
   output logic [ADDR_W-1:0]       mem_addr_o,
   output logic [LANES-1:0]        mem_ce_n_o,
   output logic [LANES-1:0]        mem_we_n_o,
   output logic                    mem_oe_n_o,
   output logic [LANES*LANE_W-1:0] mem_dq_o,
   output logic                    mem_dq_oe_o
);
   localparam int DW   = LANES * LANE_W;
   localparam int MAXC = max2(max2(RD_CYC, WP_CYC), REC_CYC);
   localparam int CW   = (MAXC < 2) ? 1 : $clog2(MAXC);

   seq_state_e      st_q;
   logic            t_load, t_zero;
   logic [CW-1:0]   t_val;
   logic [DW-1:0]   wdata_q;

   always_comb begin
      t_load = 1'b0;
      t_val  = CW'(REC_CYC - 1);
      unique case (st_q)
         ST_IDLE: begin
            t_load = req_i;
            t_val  = we_i ? CW'(WP_CYC - 1) : CW'(RD_CYC - 1);
         end
         ST_READ, ST_WRITE: t_load = t_zero;
         default: t_load = 1'b0;
      endcase
   end

   sram_lane_timer #(.CW(CW)) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (t_load),
      .load_val_i (t_val),
      .zero_o     (t_zero)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q        <= ST_IDLE;
         mem_addr_o  <= '0;
         wdata_q     <= '0;
         sel_o       <= '0;
         mem_ce_n_o  <= '1;
         mem_we_n_o  <= '1;
         mem_oe_n_o  <= 1'b1;
         mem_dq_oe_o <= 1'b0;
      end else begin
         unique case (st_q)
            ST_IDLE: if (req_i) begin
               mem_addr_o <= addr_i;
               wdata_q    <= wdata_i;
               sel_o      <= be_i;
               mem_ce_n_o <= ~be_i;
               if (we_i) begin
                  mem_we_n_o  <= ~be_i;
                  mem_dq_oe_o <= 1'b1;
                  st_q        <= ST_WRITE;
               end else begin
                  mem_oe_n_o  <= 1'b0;
                  st_q        <= ST_READ;
               end
            end
            ST_READ: if (t_zero) begin
               mem_ce_n_o <= '1;
               mem_oe_n_o <= 1'b1;
               st_q       <= ST_RECOV;
            end
            ST_WRITE: if (t_zero) begin
               mem_ce_n_o <= '1;
               mem_we_n_o <= '1;
               st_q       <= ST_RECOV;
            end
            default: begin
               mem_dq_oe_o <= 1'b0;
               if (t_zero) st_q <= ST_IDLE;
            end
         endcase
      end
   end

   assign ready_o  = (st_q == ST_IDLE);
   assign cap_o    = (st_q == ST_READ) && t_zero;
   assign mem_dq_o = wdata_q;
endmodule

// File: rtl/sram_lane_rdcap.sv
module sram_lane_rdcap #(
   parameter int LANES  = 4,
   parameter int LANE_W = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    cap_i,
   input  logic [LANES-1:0]        sel_i,
   input  logic [LANES*LANE_W-1:0] dq_i,
   output logic [LANES*LANE_W-1:0] rdata_o,
   output logic                    rvalid_o
);
   for (genvar l = 0; l < LANES; l++) begin : g_lane
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            rdata_o[l*LANE_W +: LANE_W] <= '0;
         else if (cap_i)
            rdata_o[l*LANE_W +: LANE_W] <= sel_i[l] ? dq_i[l*LANE_W +: LANE_W] : '0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rvalid_o <= 1'b0;
      else        rvalid_o <= cap_i;
   end
endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
   import sram_lane_pkg::*;
#(
   parameter int ADDR_W        = 19,
   parameter int LANES         = 4,
   parameter int LANE_W        = 8,
   parameter int CLK_PERIOD_PS = 10000,
   parameter int T_ACCESS_PS   = 25000,
   parameter int T_WPULSE_PS   = 20000,
   parameter int T_WEHIGH_PS   = 5000,
   parameter int T_HOLD_PS     = 2000
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    req_i,
   input  logic                    we_i,
   input  logic [ADDR_W-1:0]       addr_i,
   input  logic [LANES*LANE_W-1:0] wdata_i,
   input  logic [LANES-1:0]        be_i,
   output logic                    ready_o,
   output logic                    rvalid_o,
   output logic [LANES*LANE_W-1:0] rdata_o,
   output logic [ADDR_W-1:0]       mem_addr_o,
   output logic [LANES-1:0]        mem_ce_n_o,
   output logic [LANES-1:0]        mem_we_n_o,
   output logic                    mem_oe_n_o,
   output logic [LANES*LANE_W-1:0] mem_dq_o,
   output logic                    mem_dq_oe_o,
   input  logic [LANES*LANE_W-1:0] mem_dq_i
);
   localparam int RD_CYC  = ceil_cycles(T_ACCESS_PS, CLK_PERIOD_PS);
   localparam int WP_CYC  = ceil_cycles(T_WPULSE_PS, CLK_PERIOD_PS);
   localparam int REC_CYC = ceil_cycles(max2(T_WEHIGH_PS, T_HOLD_PS), CLK_PERIOD_PS);

   if (LANES < 1 || LANE_W < 1 || ADDR_W < 1 || CLK_PERIOD_PS < 1) begin : g_param_bad
      $error("sram_lane_ctrl: widths and clock period must be positive");
   end

   logic             cap;
   logic [LANES-1:0] sel;

   sram_lane_seq #(
      .ADDR_W (ADDR_W), .LANES (LANES), .LANE_W (LANE_W),
      .RD_CYC (RD_CYC), .WP_CYC (WP_CYC), .REC_CYC (REC_CYC)
   ) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_i       (req_i),
      .we_i        (we_i),
      .addr_i      (addr_i),
      .wdata_i     (wdata_i),
      .be_i        (be_i),
      .ready_o     (ready_o),
      .cap_o       (cap),
      .sel_o       (sel),
      .mem_addr_o  (mem_addr_o),
      .mem_ce_n_o  (mem_ce_n_o),
      .mem_we_n_o  (mem_we_n_o),
      .mem_oe_n_o  (mem_oe_n_o),
      .mem_dq_o    (mem_dq_o),
      .mem_dq_oe_o (mem_dq_oe_o)
   );

   sram_lane_rdcap #(.LANES(LANES), .LANE_W(LANE_W)) u_rdcap (
      .clk      (clk),
      .rst_n    (rst_n),
      .cap_i    (cap),
      .sel_i    (sel),
      .dq_i     (mem_dq_i),
      .rdata_o  (rdata_o),
      .rvalid_o (rvalid_o)
   );
endmodule

// File: rtl/sram_lane_ctrl_chk.sv
module sram_lane_ctrl_chk #(
   parameter int ADDR_W = 19,
   parameter int LANES  = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_i,
   input logic              ready_o,
   input logic              rvalid_o,
   input logic [ADDR_W-1:0] mem_addr_o,
   input logic [LANES-1:0]  mem_ce_n_o,
   input logic [LANES-1:0]  mem_we_n_o,
   input logic              mem_oe_n_o,
   input logic              mem_dq_oe_o
);
   p_idle_standby_r1: assert property (@(posedge clk) disable iff (!rst_n)
      ready_o |-> (&mem_ce_n_o && &mem_we_n_o && mem_oe_n_o && !mem_dq_oe_o));

   p_strobe_needs_select_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (|(~mem_we_n_o & mem_ce_n_o)) == 1'b0);

   p_oe_high_in_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !(&mem_we_n_o) |-> mem_oe_n_o);

   p_no_contention_r3: assert property (@(posedge clk) disable iff (!rst_n)
      mem_dq_oe_o |-> mem_oe_n_o);

   p_read_strobes_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_oe_n_o |-> &mem_we_n_o);

   p_rvalid_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rvalid_o |=> !rvalid_o);

   p_rvalid_after_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rvalid_o |-> (mem_oe_n_o && !$past(mem_oe_n_o)));

   p_ready_drops_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (req_i && ready_o) |=> !ready_o);

   p_addr_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !ready_o |=> $stable(mem_addr_o));
endmodule

bind sram_lane_ctrl sram_lane_ctrl_chk #(.ADDR_W(ADDR_W), .LANES(LANES)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .req_i       (req_i),
   .ready_o     (ready_o),
   .rvalid_o    (rvalid_o),
   .mem_addr_o  (mem_addr_o),
   .mem_ce_n_o  (mem_ce_n_o),
   .mem_we_n_o  (mem_we_n_o),
   .mem_oe_n_o  (mem_oe_n_o),
   .mem_dq_oe_o (mem_dq_oe_o)
);

// File: tb/sram_lane_ctrl_test.sv
module sram_lane_ctrl_test;
   localparam int PER = 10000;
   localparam int RD  = (25000 + PER - 1) / PER;
   localparam int WP  = (20000 + PER - 1) / PER;
   localparam int REC = (5000 + PER - 1) / PER;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_i = 1'b0, we_i = 1'b0;
   logic [18:0] addr_i = '0;
   logic [31:0] wdata_i = '0;
   logic [3:0]  be_i = '0;
   logic        ready_o, rvalid_o, mem_oe_n_o, mem_dq_oe_o;
   logic [31:0] rdata_o, mem_dq_o, mem_dq_i;
   logic [18:0] mem_addr_o;
   logic [3:0]  mem_ce_n_o, mem_we_n_o;

   int n_chk = 0, n_fail = 0;
   int cyc = 0, gap = 0, min_gap = 1000;
   bit seen_pulse = 0;

   logic [7:0] mem [4][256];
   logic [7:0] ref_mem [4][256];

   always #5 clk = ~clk;

   sram_lane_ctrl uut (.*);

   // behavioural memory: lanes drive only when selected for a read
   always_comb begin
      for (int l = 0; l < 4; l++)
         mem_dq_i[l*8 +: 8] = (!mem_ce_n_o[l] && !mem_oe_n_o && mem_we_n_o[l])
                              ? mem[l][mem_addr_o[7:0]] : 8'h5A;
   end

   always @(negedge clk) begin
      for (int l = 0; l < 4; l++)
         if (!mem_ce_n_o[l] && !mem_we_n_o[l] && mem_dq_oe_o)
            mem[l][mem_addr_o[7:0]] <= mem_dq_o[l*8 +: 8];
   end

   // strobe-high gap between write pulses, and watchdog
   always @(negedge clk) begin
      cyc <= cyc + 1;
      if (&mem_we_n_o) gap <= gap + 1;
      else begin
         if (seen_pulse && gap > 0 && gap < min_gap) min_gap <= gap;
         seen_pulse <= 1'b1;
         gap <= 0;
      end
      if (cyc > 20000) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: act=%0d cycles exp<=20000", cyc);
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: act=%h exp=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] ref_word(input logic [7:0] a, input logic [3:0] be);
      logic [31:0] w = '0;
      for (int l = 0; l < 4; l++) if (be[l]) w[l*8 +: 8] = ref_mem[l][a];
      return w;
   endfunction

   task automatic t_reset();
      for (int l = 0; l < 4; l++)
         for (int i = 0; i < 256; i++) begin
            mem[l][i]     = 8'(i) ^ 8'(l << 4) ^ 8'h81;
            ref_mem[l][i] = 8'(i) ^ 8'(l << 4) ^ 8'h81;
         end
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(ready_o && !rvalid_o, "R1 reset ready/rvalid", {30'd0, ready_o, rvalid_o}, 32'h2);
      chk(mem_ce_n_o == 4'hF && mem_we_n_o == 4'hF && mem_oe_n_o && !mem_dq_oe_o,
          "R1 reset standby pins", {22'd0, mem_ce_n_o, mem_we_n_o, mem_oe_n_o, mem_dq_oe_o}, 32'h3FE);
   endtask

   task automatic t_write(input logic [18:0] a, input logic [31:0] d, input logic [3:0] be);
      int busy = 0, we_low = 0, drv = 0;
      bit bad2 = 0, bad3 = 0, bad8 = 0;
      chk(ready_o, "R7 ready before write", {31'd0, ready_o}, 32'd1);
      addr_i = a; wdata_i = d; be_i = be; we_i = 1'b1; req_i = 1'b1;
      @(negedge clk);
      req_i = 1'b0; addr_i = ~a;
      while (!ready_o && busy < 50) begin
         busy++;
         if (mem_we_n_o != 4'hF) begin
            we_low++;
            if (mem_we_n_o != ~be || mem_ce_n_o != ~be) bad2 = 1;
            if (!mem_oe_n_o || !mem_dq_oe_o || mem_dq_o != d) bad3 = 1;
         end else if (mem_ce_n_o != 4'hF) bad2 = 1;
         if (mem_dq_oe_o) drv++;
         if (mem_addr_o != a) bad8 = 1;
         @(negedge clk);
      end
      for (int l = 0; l < 4; l++) if (be[l]) ref_mem[l][a[7:0]] = d[l*8 +: 8];
      chk(we_low == WP, "R2 write pulse length", we_low, WP);
      chk(!bad2, "R2 lane strobes match mask", {28'd0, be}, {28'd0, be});
      chk(!bad3 && drv == WP + 1, "R3 oe high and drive window", drv, WP + 1);
      chk(!bad8, "R8 address held during write", mem_addr_o, a);
      chk(busy == WP + REC, "R9 write busy cycles", busy, WP + REC);
   endtask

   task automatic t_read(input logic [18:0] a, input logic [3:0] be, input logic [18:0] a_mid, input bit hold_req);
      int busy = 0, oe_low = 0, vcnt = 0;
      logic [31:0] got = '0, exp;
      bit bad4 = 0, bad8 = 0;
      exp = ref_word(a[7:0], be);
      chk(ready_o, "R7 ready before read", {31'd0, ready_o}, 32'd1);
      addr_i = a; be_i = be; we_i = 1'b0; req_i = 1'b1;
      @(negedge clk);
      if (!hold_req) req_i = 1'b0;
      addr_i = a_mid;
      while (!ready_o && busy < 50) begin
         busy++;
         if (!mem_oe_n_o) begin
            oe_low++;
            if (mem_ce_n_o != ~be || mem_we_n_o != 4'hF) bad4 = 1;
         end else if (mem_ce_n_o != 4'hF) bad4 = 1;
         if (rvalid_o) begin vcnt++; got = rdata_o; end
         if (mem_addr_o != a) bad8 = 1;
         @(negedge clk);
      end
      req_i = 1'b0;
      chk(oe_low == RD, "R4 read enable length", oe_low, RD);
      chk(!bad4, "R4 read lane selects", {28'd0, mem_ce_n_o}, 32'hF);
      chk(vcnt == 1, "R5 single valid pulse", vcnt, 1);
      chk(got == exp, "R5 read data", got, exp);
      chk(!bad8, "R8 address held during read", mem_addr_o, a);
      chk(busy == RD + REC, "R9 read busy cycles", busy, RD + REC);
      if (hold_req) chk(vcnt == 1 && busy == RD + REC, "R7 held request not retaken", vcnt, 1);
   endtask

   task automatic t_idle(input int n);
      bit bad = 0;
      repeat (n) begin
         @(negedge clk);
         if (!ready_o || mem_ce_n_o != 4'hF || mem_we_n_o != 4'hF || !mem_oe_n_o || mem_dq_oe_o || rvalid_o)
            bad = 1;
      end
      chk(!bad, "R1 idle standby", {31'd0, bad}, 32'd0);
   endtask

   initial begin
      t_reset();
      t_idle(4);
      t_write(19'h40012, 32'hDEADBEEF, 4'hF);
      t_read(19'h40012, 4'hF, 19'h00033, 1'b0);
      t_write(19'h00034, 32'h11223344, 4'b0100);
      t_read(19'h00034, 4'hF, 19'h00000, 1'b0);
      t_read(19'h00077, 4'b0101, 19'h7FFFF, 1'b0);
      t_write(19'h000A0, 32'hCAFEF00D, 4'b0011);
      t_write(19'h000A1, 32'h0BADC0DE, 4'b1001);
      t_read(19'h000A0, 4'b0011, 19'h000A1, 1'b1);
      t_read(19'h000A1, 4'hF, 19'h000A0, 1'b0);
      t_idle(3);
      chk(min_gap >= REC + 1, "R6 strobe-high gap between writes", min_gap, REC + 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end
endmodule